// File: doc/BRIEF.md
# Keyed configuration port for serial and timer devices

This block is a plug-and-play style configuration port. Software reaches it through two adjacent I/O addresses on a simple I/O bus: the lower one takes a register index and the upper one carries the data for that index. The configuration space stays closed until a two-byte key is written to the index address. A second two-byte key closes it again. While the space is closed, the data port does nothing and reads of the port return all ones.

A device-select register picks which per-device bank the device indices reach. Each bank holds an activate flag and a 16-bit I/O base. The base is written high byte first or low byte first, at two indices. One global register, reachable whatever device is selected, holds a UART clock predivider code and an interrupt enable. Its bit 1 is read-only. The decoded activate flags, base addresses, predivider code and interrupt enable leave the block as plain outputs. These outputs drive the UARTs and the timer, which sit outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed and every activate flag is 0. Every base address is 0x0000, the predivider code is 00 and the interrupt enable is 0.
- R2: Writing 0x80 and then 0x86, as consecutive writes to the index address (BASE_ADDR), opens the port. While the port is closed, data-port writes change nothing, and reads of either port address return 0xFF.
- R3: During opening, any byte other than the expected one sends the key matcher back to its first step. A 0x80 seen at the second step keeps the matcher at the second step.
- R4: Writing 0x68 and then 0x08, as consecutive writes to the index address, closes the port. A 0x68 at the second step keeps the matcher there, and any other byte returns it to the open state. All device outputs keep their values across closing.
- R5: While the port is open, an index-address write stores the index, and an index-address read returns it. The data address is BASE_ADDR+1.
- R6: Index 0x07 holds the 8-bit device number. For device numbers of NUM_DEV or more, device indices read 0x00 and ignore writes.
- R7: Index 0x30 of the selected device sets its activate flag from bit 0. The register reads back as 0x00 or 0x01.
- R8: Index 0x60 sets bits [15:8] and index 0x61 sets bits [7:0] of the selected device's base. Both bytes read back.
- R9: Global index 0x29 is reachable for any device number. Its bits [3:2] set the predivider code, where 00 means /1, 01 means /8 and 10 means /26, and its bit 0 sets the interrupt enable.
- R10: Bit 1 of index 0x29 is read-only and reads 0. Bits [7:4] also read 0.
- R11: A write of code 11 to bits [3:2] of index 0x29 leaves the predivider code unchanged. Bit 0 is still written.
- R12: Indices with no register read 0x00, and writes to them have no effect.
- R13: Addresses other than the two port addresses are ignored, and io_rdata is 0x00 unless a port address is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| dev_active | output | NUM_DEV | Activate flag per device |
| dev_base | output | NUM_DEV*16 | I/O base per device, device i at bits [16i+15:16i] |
| uart_prediv | output | 2 | Predivider code |
| irq_en | output | 1 | Device interrupt enable |

## Verification
A wrong key-matcher state shows up on the first read of either port address. That read returns 0xFF where the index value was expected, or the reverse. A write that the wrong state let through appears on dev_active, dev_base or uart_prediv on the next clock. A stale or corrupted index or device number shows up on the next data-port read, or on the next data write, which lands on the wrong output. The bench compares every output against its model after every clock, so a divergence is reported within the same cycle it first becomes visible.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    KEY_SHUT, KEY_SHUT_HALF, KEY_OPEN, KEY_OPEN_HALF
  } key_state_e;

  localparam logic [7:0] OPEN_BYTE0  = 8'h80;
  localparam logic [7:0] OPEN_BYTE1  = 8'h86;
  localparam logic [7:0] SHUT_BYTE0  = 8'h68;
  localparam logic [7:0] SHUT_BYTE1  = 8'h08;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_GLOBAL  = 8'h29;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [1:0] PREDIV_RSVD = 2'b11;
endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       cfg_open
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        KEY_SHUT:      state_d = (key_byte == OPEN_BYTE0) ? KEY_SHUT_HALF : KEY_SHUT;
        KEY_SHUT_HALF: state_d = (key_byte == OPEN_BYTE1) ? KEY_OPEN :
                                 (key_byte == OPEN_BYTE0) ? KEY_SHUT_HALF : KEY_SHUT;
        KEY_OPEN:      state_d = (key_byte == SHUT_BYTE0) ? KEY_OPEN_HALF : KEY_OPEN;
        KEY_OPEN_HALF: state_d = (key_byte == SHUT_BYTE1) ? KEY_SHUT :
                                 (key_byte == SHUT_BYTE0) ? KEY_OPEN_HALF : KEY_OPEN;
        default:       state_d = KEY_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_SHUT;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == KEY_OPEN) || (state_q == KEY_OPEN_HALF);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] base,
  output logic [7:0]  rd_byte
);
  logic        act_q, act_d;
  logic [15:0] base_q, base_d;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    if (wr_en) begin
      if (idx == IDX_ACT)     act_d        = wdata[0];
      if (idx == IDX_BASE_HI) base_d[15:8] = wdata;
      if (idx == IDX_BASE_LO) base_d[7:0]  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_ACT:     rd_byte = {7'd0, act_q};
      IDX_BASE_HI: rd_byte = base_q[15:8];
      IDX_BASE_LO: rd_byte = base_q[7:0];
      default:     rd_byte = 8'h00;
    endcase
  end

  assign active = act_q;
  assign base   = base_q;
endmodule

// File: rtl/sio_global_reg.sv
module sio_global_reg
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  input  logic       wr_irq,
  output logic [1:0] prediv,
  output logic       irq_en,
  output logic [7:0] rd_byte
);
  logic [1:0] code_q, code_d;
  logic       irq_q, irq_d;

  always_comb begin
    code_d = code_q;
    irq_d  = irq_q;
    if (wr_en) begin
      irq_d = wr_irq;
      if (wr_code != PREDIV_RSVD) code_d = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 2'b00;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= irq_d;
    end
  end

  assign prediv  = code_q;
  assign irq_en  = irq_q;
  assign rd_byte = {4'd0, code_q, 1'b0, irq_q};
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E,
  parameter int                NUM_DEV   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [NUM_DEV*16-1:0] dev_base,
  output logic [1:0]            uart_prediv,
  output logic                  irq_en
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;
  localparam logic [7:0]        DEV_LIMIT = 8'(NUM_DEV);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       cfg_open;
  logic       idx_hit, dat_hit, dat_wr, dev_ok;
  logic [7:0] idx_q, idx_d, devsel_q, devsel_d;
  logic [7:0] glob_rd, dev_rd, data_val;
  logic [7:0] bank_rd [NUM_DEV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign idx_hit = (io_addr == BASE_ADDR);
  assign dat_hit = (io_addr == DATA_ADDR);
  assign dat_wr  = io_wr && dat_hit && cfg_open;
  assign dev_ok  = (devsel_q < DEV_LIMIT);

  sio_key_matcher u_key (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .key_wr   (io_wr && idx_hit),
    .key_byte (io_wdata),
    .cfg_open (cfg_open)
  );

  always_comb begin
    idx_d    = idx_q;
    devsel_d = devsel_q;
    if (io_wr && idx_hit && cfg_open)      idx_d    = io_wdata;
    if (dat_wr && (idx_q == IDX_DEVSEL))   devsel_d = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q    <= 8'h00;
      devsel_q <= 8'h00;
    end else begin
      idx_q    <= idx_d;
      devsel_q <= devsel_d;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    sio_dev_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (dat_wr && dev_ok && (devsel_q == 8'(i))),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .active  (dev_active[i]),
      .base    (dev_base[16*i +: 16]),
      .rd_byte (bank_rd[i])
    );
  end

  sio_global_reg u_glob (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (dat_wr && (idx_q == IDX_GLOBAL)),
    .wr_code (io_wdata[3:2]),
    .wr_irq  (io_wdata[0]),
    .prediv  (uart_prediv),
    .irq_en  (irq_en),
    .rd_byte (glob_rd)
  );

  always_comb begin
    dev_rd = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (devsel_q == 8'(i)) dev_rd = bank_rd[i];
  end

  always_comb begin
    unique case (idx_q)
      IDX_DEVSEL:                        data_val = devsel_q;
      IDX_GLOBAL:                        data_val = glob_rd;
      IDX_ACT, IDX_BASE_HI, IDX_BASE_LO: data_val = dev_ok ? dev_rd : 8'h00;
      default:                           data_val = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && idx_hit)      io_rdata = cfg_open ? idx_q    : 8'hFF;
    else if (io_rd && dat_hit) io_rdata = cfg_open ? data_val : 8'hFF;
  end
endmodule

module sio_cfg_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E,
  parameter int                NUM_DEV   = 8
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [ADDR_W-1:0]     io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic [NUM_DEV-1:0]    dev_active,
  input logic [NUM_DEV*16-1:0] dev_base,
  input logic [1:0]            uart_prediv,
  input logic                  cfg_open,
  input logic [7:0]            idx_q
);
  // R2: a closed port answers 0xFF on both addresses
  a_r2_shut_reads_ff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_open && io_rd && (io_addr == BASE_ADDR || io_addr == BASE_ADDR + 1'b1)) |-> io_rdata == 8'hFF);

  // R2: a closed port ignores data writes
  a_r2_shut_no_effect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_open && io_wr && io_addr == BASE_ADDR + 1'b1)
      |=> ($stable(dev_active) && $stable(dev_base) && $stable(uart_prediv)));

  // R2: opening only follows the second key byte on the index address
  a_r2_open_key: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h86));

  // R4: closing only follows the second lock byte on the index address
  a_r4_shut_key: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(cfg_open) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h08));

  // R11: the reserved predivider code is never written and never held
  a_r11_keep_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_open && io_wr && io_addr == BASE_ADDR + 1'b1 && idx_q == 8'h29 && io_wdata[3:2] == 2'b11)
      |=> $stable(uart_prediv));
  a_r11_no_rsvd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uart_prediv != 2'b11);

  // R13: nothing is returned without a port read
  a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !io_rd |-> io_rdata == 8'h00);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)) i_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .dev_active  (dev_active),
  .dev_base    (dev_base),
  .uart_prediv (uart_prediv),
  .cfg_open    (cfg_open),
  .idx_q       (idx_q)
);

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  localparam int         NDEV = 8;
  localparam logic [15:0] BA  = 16'h004E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [NDEV-1:0]    dev_active;
  logic [NDEV*16-1:0] dev_base;
  logic [1:0]  uart_prediv;
  logic        irq_en;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  sio_cfg_port #(.ADDR_W(16), .BASE_ADDR(BA), .NUM_DEV(NDEV)) i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
    .dev_base(dev_base), .uart_prediv(uart_prediv), .irq_en(irq_en));

  // behavioural reference model
  bit       m_open, m_half;
  int       m_idx, m_sel, m_code, m_irq;
  bit       m_act [NDEV];
  int       m_base [NDEV];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_half = 0; m_idx = 0; m_sel = 0; m_code = 0; m_irq = 0;
      for (int i = 0; i < NDEV; i++) begin m_act[i] = 0; m_base[i] = 0; end
    end else if (io_wr && io_addr == BA) begin
      int b;
      b = io_wdata;
      if (m_open) begin
        m_idx = b;
        if (m_half) begin
          if (b == 'h08) begin m_open = 0; m_half = 0; end
          else m_half = (b == 'h68);
        end else m_half = (b == 'h68);
      end else begin
        if (m_half && b == 'h86) begin m_open = 1; m_half = 0; end
        else m_half = (b == 'h80);
      end
    end else if (io_wr && io_addr == BA + 1 && m_open) begin
      int b;
      b = io_wdata;
      if (m_idx == 'h07) m_sel = b;
      else if (m_idx == 'h29) begin
        m_irq = b % 2;
        if (((b / 4) % 4) != 3) m_code = (b / 4) % 4;
      end else if (m_sel < NDEV) begin
        if (m_idx == 'h30) m_act[m_sel] = b % 2;
        if (m_idx == 'h60) m_base[m_sel] = (m_base[m_sel] % 256) + b * 256;
        if (m_idx == 'h61) m_base[m_sel] = (m_base[m_sel] / 256) * 256 + b;
      end
    end
  end

  function automatic int model_rd();
    if (!io_rd) return 0;
    if (io_addr == BA) return m_open ? m_idx : 'hFF;
    if (io_addr != BA + 1) return 0;
    if (!m_open) return 'hFF;
    case (m_idx)
      'h07: return m_sel;
      'h29: return m_code * 4 + m_irq;
      'h30: return (m_sel < NDEV) ? int'(m_act[m_sel]) : 0;
      'h60: return (m_sel < NDEV) ? m_base[m_sel] / 256 : 0;
      'h61: return (m_sel < NDEV) ? m_base[m_sel] % 256 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      for (int i = 0; i < NDEV; i++) begin
        check(dev_active[i] == m_act[i], "R7 dev_active", int'(dev_active[i]), int'(m_act[i]));
        check(int'(dev_base[16*i +: 16]) == m_base[i], "R8 dev_base", int'(dev_base[16*i +: 16]), m_base[i]);
      end
      check(int'(uart_prediv) == m_code, "R9 uart_prediv", int'(uart_prediv), m_code);
      check(int'(irq_en) == m_irq, "R9 irq_en", int'(irq_en), m_irq);
      check(int'(io_rdata) == model_rd(), "R5 io_rdata", int'(io_rdata), model_rd());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input int exp, input string req);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 check(int'(io_rdata) == exp, req, int'(io_rdata), exp);
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(BA, i); wr(BA + 16'd1, d);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dev_active == '0, "R1 active", int'(dev_active), 0);
    check(dev_base == '0, "R1 base", 0, 0);
    check(uart_prediv == 2'b00 && irq_en == 1'b0, "R1 prediv", int'(uart_prediv), 0);
    // R2 closed port
    rd_chk(BA, 'hFF, "R2 index read closed");
    reg_wr(8'h30, 8'h01);
    check(dev_active == '0, "R2 write ignored", int'(dev_active), 0);
    rd_chk(BA + 16'd1, 'hFF, "R2 data read closed");
    // R3 broken key then restart via repeated 0x80
    wr(BA, 8'h80); wr(BA, 8'h11); wr(BA, 8'h86);
    rd_chk(BA, 'hFF, "R3 wrong byte resets matcher");
    wr(BA, 8'h80); wr(BA, 8'h80); wr(BA, 8'h86);
    rd_chk(BA, 'h00, "R3 repeated 0x80 keeps second step");
    // R5 index readback
    wr(BA, 8'h5A);
    rd_chk(BA, 'h5A, "R5 index readback");
    // R7/R8 device 5
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h30, 8'hFF);
    rd_chk(BA + 16'd1, 'h01, "R7 activate readback");
    check(dev_active == 8'h20, "R7 device 5 active", int'(dev_active), 'h20);
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    check(dev_base[16*5 +: 16] == 16'h1234, "R8 base device 5", int'(dev_base[16*5 +: 16]), 'h1234);
    rd_chk(BA + 16'd1, 'h34, "R8 low byte readback");
    // R6 device 6, then out-of-range device
    reg_wr(8'h07, 8'h06); reg_wr(8'h61, 8'hF8); reg_wr(8'h60, 8'h03);
    check(dev_base[16*6 +: 16] == 16'h03F8, "R6 device 6 base", int'(dev_base[16*6 +: 16]), 'h03F8);
    reg_wr(8'h07, 8'h20); reg_wr(8'h30, 8'h01);
    rd_chk(BA + 16'd1, 'h00, "R6 out-of-range device reads 0");
    check(dev_active == 8'h20, "R6 out-of-range write ignored", int'(dev_active), 'h20);
    wr(BA, 8'h07);
    rd_chk(BA + 16'd1, 'h20, "R6 device number readback");
    // R9/R10/R11 global register with out-of-range device selected
    reg_wr(8'h29, 8'hFF);
    rd_chk(BA + 16'd1, 'h01, "R11 reserved code kept, R10 bit1 reads 0");
    check(uart_prediv == 2'b00 && irq_en, "R11 code held", int'(uart_prediv), 0);
    reg_wr(8'h29, 8'h08);
    check(uart_prediv == 2'b10 && !irq_en, "R9 divide by 26", int'(uart_prediv), 2);
    reg_wr(8'h29, 8'h06);
    rd_chk(BA + 16'd1, 'h04, "R10 bit1 ignored, R9 code 01");
    reg_wr(8'h29, 8'h0D);
    check(uart_prediv == 2'b01 && irq_en, "R11 code held again", int'(uart_prediv), 1);
    // R12 unimplemented index
    reg_wr(8'h55, 8'hAA);
    rd_chk(BA + 16'd1, 'h00, "R12 unimplemented index");
    // R13 foreign addresses
    wr(BA + 16'd2, 8'h68); wr(16'h002E, 8'h08);
    rd_chk(BA + 16'd2, 'h00, "R13 foreign address read");
    rd_chk(BA, 'h55, "R13 foreign writes leave index");
    // R4 close with interruption then repeated 0x68
    wr(BA, 8'h68); wr(BA, 8'h00); wr(BA, 8'h08);
    rd_chk(BA, 'h08, "R4 broken lock stays open");
    wr(BA, 8'h68); wr(BA, 8'h68); wr(BA, 8'h08);
    rd_chk(BA, 'hFF, "R4 closed");
    check(dev_active == 8'h20 && uart_prediv == 2'b01, "R4 outputs kept", int'(dev_active), 'h20);
    reg_wr(8'h29, 8'h08);
    check(uart_prediv == 2'b01, "R2 closed global write ignored", int'(uart_prediv), 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule